// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry Out

A purely combinational unit that moves a 32-bit word left or right, or rotates it, and produces the new carry together with negative and zero flags. It sits in the execute stage of a small integer datapath. The caller supplies the operand, the current carry flag and an operation code. The amount comes from one of two places: a general register, of which only the low byte counts, or a 5-bit field taken from the instruction word.

The unit applies the amount rules itself. Register amounts above the word width saturate. An immediate of zero for the two right shifts stands for a full 32-bit shift. An effective amount of zero passes both the data and the carry through untouched. The overflow flag is not an output, so the unit cannot change it.

Top module: `shift_unit`

## Requirements
- R1: With `use_imm` = 0 the amount is `amt_reg[7:0]` and bits [31:8] of `amt_reg` have no effect on any output.
- R2: An effective amount of 0 gives `dout` = `din` and `c_out` = `c_in` for every operation. With `use_imm` = 1 and `amt_imm` = 0, LSL (`op` = 00) and ROR (`op` = 11) use an amount of 0.
- R3: LSL (`op` = 00) by n from 1 to 32 gives `din << n` with `c_out` = `din[32-n]`. For n above 32, `dout` = 0 and `c_out` = 0.
- R4: LSR (`op` = 01) by n from 1 to 32 gives `din >> n` with `c_out` = `din[n-1]`. For n above 32, `dout` = 0 and `c_out` = 0.
- R5: With `use_imm` = 1, an `amt_imm` of 0 for LSR (`op` = 01) or ASR (`op` = 10) acts as an amount of 32.
- R6: ASR (`op` = 10) of a word with bit 31 set, by n from 1 to 31, fills with ones and gives `c_out` = `din[n-1]`. For n of 32 or more, `dout` is all ones and `c_out` = 1.
- R7: ASR of a word with bit 31 clear gives the same result and carry as LSR by the same amount.
- R8: ROR (`op` = 11) by a nonzero n rotates right by n mod 32, and `c_out` equals the new bit 31. When n is a nonzero multiple of 32, `dout` = `din` and `c_out` = `din[31]`.
- R9: `n_out` equals `dout[31]`, and `z_out` is 1 exactly when `dout` is 0, for every operation and amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Operand word |
| amt_reg | input | 32 | Register holding the shift amount; only the low byte is used |
| amt_imm | input | 5 | Shift amount field from the instruction |
| use_imm | input | 1 | 1 selects `amt_imm`, 0 selects `amt_reg` |
| op | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| c_in | input | 1 | Current carry flag |
| dout | output | 32 | Shifted or rotated word |
| c_out | output | 1 | New carry flag |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |

## Verification
The assertions watch, on every input change, properties that hold for whole classes of operands:
- a zero amount passes data and carry through, and upper register bits are ignored at amount zero;
- left shifts beyond the width clear both data and carry;
- a negative operand under an arithmetic shift of 32 or more saturates to all ones with carry set;
- a rotate never changes the count of one bits.

The exact carry bit picked for each amount, the immediate-zero-means-32 rule and the flag values can only be shown by the bench. It sweeps every register amount from 0 to 255 and every immediate value for each operation, and compares each result with a bit-serial reference.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int W  = 32,
  parameter int AW = 8,
  parameter int IW = 5
) (
  input  logic [W-1:0]  din,
  input  logic [W-1:0]  amt_reg,
  input  logic [IW-1:0] amt_imm,
  input  logic          use_imm,
  input  logic [1:0]    op,
  input  logic          c_in,
  output logic [W-1:0]  dout,
  output logic          c_out,
  output logic          n_out,
  output logic          z_out
);
  localparam int EW = AW + 1;
  localparam int KW = $clog2(W);
  localparam logic [EW-1:0] FULL = EW'(W);

  typedef enum logic [1:0] {OP_LSL, OP_LSR, OP_ASR, OP_ROR} op_e;

  logic [EW-1:0]  amt;
  logic [W:0]     left_ext, right_ext, arith_ext;
  logic [2*W-1:0] rot_ext;
  logic [KW-1:0]  k;
  logic           right_kind;

  assign right_kind = (op == OP_LSR) || (op == OP_ASR);
  assign amt = use_imm ? ((right_kind && amt_imm == '0) ? FULL : EW'(amt_imm))
                       : EW'(amt_reg[AW-1:0]);

  assign k         = amt[KW-1:0];
  assign left_ext  = {1'b0, din} << amt;
  assign right_ext = {din, 1'b0} >> amt;
  assign arith_ext = $signed({din, 1'b0}) >>> amt;
  assign rot_ext   = {din, din} >> k;

  always_comb begin
    dout  = din;
    c_out = c_in;
    if (amt != '0) begin
      case (op_e'(op))
        OP_LSL: {c_out, dout} = left_ext;
        OP_LSR: {dout, c_out} = right_ext;
        OP_ASR: {dout, c_out} = arith_ext;
        default: begin
          dout  = rot_ext[W-1:0];
          c_out = rot_ext[W-1];
        end
      endcase
    end
  end

  assign n_out = dout[W-1];
  assign z_out = (dout == '0);

  always_comb begin
    if (!use_imm && amt_reg[AW-1:0] == '0 && amt_reg[W-1:AW] != '0)
      a_r1_upper_bits_ignored: assert (dout == din && c_out == c_in);
    if (use_imm && amt_imm == '0 && !right_kind)
      a_r2_imm_zero_passthrough: assert (dout == din && c_out == c_in);
    if (!use_imm && op == OP_LSL && amt_reg[AW-1:0] > AW'(W))
      a_r3_lsl_overrange_clears: assert (dout == '0 && !c_out);
    if (op == OP_LSR && (use_imm || amt_reg[AW-1:0] != '0))
      a_r4_lsr_top_bit_clear: assert (!dout[W-1]);
    if (op == OP_ASR && din[W-1] && use_imm && amt_imm == '0)
      a_r6_asr_negative_saturates: assert (&dout && c_out);
    if (op == OP_ASR && !din[W-1])
      a_r7_asr_positive_stays_positive: assert (!n_out);
    if (op == OP_ROR)
      a_r8_rotate_keeps_ones: assert ($countones(dout) == $countones(din));
  end
endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] din, amt_reg, dout;
  logic [4:0]  amt_imm;
  logic        use_imm, c_in, c_out, n_out, z_out;
  logic [1:0]  op;

  shift_unit u_shift_unit (
    .din(din), .amt_reg(amt_reg), .amt_imm(amt_imm), .use_imm(use_imm),
    .op(op), .c_in(c_in), .dout(dout), .c_out(c_out), .n_out(n_out), .z_out(z_out)
  );

  logic [31:0] q_d[$];
  logic        q_c[$];
  string       q_tag[$];
  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  function automatic logic [32:0] model(input logic [1:0] o, input logic [31:0] d,
                                        input int a, input logic ci);
    logic [31:0] v;
    logic c;
    v = d;
    c = ci;
    for (int i = 0; i < a; i++) begin
      case (o)
        2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic [31:0] d,
                                   input int a, input bit imm_zero_right, input bit upper);
    string t;
    if (a == 0) t = "R2";
    else if (o == 2'd0) t = "R3";
    else if (o == 2'd1) t = "R4";
    else if (o == 2'd2) t = d[31] ? "R6" : "R7";
    else t = "R8";
    if (imm_zero_right) t = {t, "/R5"};
    if (upper) t = {t, "/R1"};
    return {t, "/R9"};
  endfunction

  task automatic drive(input logic [1:0] o, input logic [31:0] d, input logic [31:0] r,
                       input logic [4:0] im, input logic ui, input logic ci);
    int a;
    bit izr;
    logic [32:0] e;
    izr = ui && im == 5'd0 && (o == 2'd1 || o == 2'd2);
    if (ui) a = izr ? 32 : int'(im);
    else    a = int'(r[7:0]);
    e = model(o, d, a, ci);
    @(posedge clk);
    op = o; din = d; amt_reg = r; amt_imm = im; use_imm = ui; c_in = ci;
    q_d.push_back(e[31:0]);
    q_c.push_back(e[32]);
    q_tag.push_back(tag_of(o, d, a, izr, !ui && r[31:8] != 24'd0));
  endtask

  always @(negedge clk) begin
    if (q_d.size() > 0) begin
      logic [31:0] ed;
      logic ec, en, ez;
      string t;
      ed = q_d.pop_front();
      ec = q_c.pop_front();
      t  = q_tag.pop_front();
      en = ed[31];
      ez = (ed == 32'd0);
      applied++;
      if (dout !== ed || c_out !== ec || n_out !== en || z_out !== ez) begin
        bad++;
        $display("FAIL %s op=%0d din=%h reg=%h imm=%0d ui=%b: actual d=%h c=%b n=%b z=%b expected d=%h c=%b n=%b z=%b",
                 t, op, din, amt_reg, amt_imm, use_imm, dout, c_out, n_out, z_out, ed, ec, en, ez);
      end
    end
  end

  logic [31:0] pats [3];

  initial begin
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h1234_5678;
    pats[2] = 32'hF0F0_0F0F;
    op = 2'd0; din = '0; amt_reg = '0; amt_imm = '0; use_imm = 1'b0; c_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // quiet inputs after reset: zero word, zero flag set (R9)
    drive(2'd0, 32'd0, 32'd0, 5'd0, 1'b0, 1'b0);
    // register form, every amount 0..255, garbage in upper bits on some (R1..R4, R6..R9)
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 256; a++)
        for (int p = 0; p < 3; p++)
          drive(2'(o), pats[p], {((a % 3) == 0) ? 24'hA5C3E1 : 24'd0, 8'(a)},
                5'd0, 1'b0, 1'(a ^ p));
    // immediate form, every field value, including zero meaning 32 (R2, R5)
    for (int o = 0; o < 4; o++)
      for (int im = 0; im < 32; im++)
        for (int p = 0; p < 3; p++)
          drive(2'(o), pats[p], 32'hFFFF_FF00, 5'(im), 1'b1, 1'(im + p));
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1-sweep watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule